// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Device

This block is the device end of a three-wire serial memory link. A host raises select, then clocks a start bit, a two-bit operation code, a six-bit word address and, for store operations, a sixteen-bit data word into the serial input. All bits are sampled on rising serial-clock edges and sent most significant bit first. The block holds 64 words of 16 bits in a register array that stands in for the memory cells. It decodes seven instructions and guards every modifying instruction with an enable latch.

Reads send a leading zero bit and then the addressed word. While select stays high, reading carries on through ascending addresses. Erase and store operations are armed by their final bit and are launched by the following select drop. They then run a self-timed cycle that is counted on the free-running system clock. During that cycle a host that raises select again sees busy (0) or ready (1) on the serial output.

The serial pins are oversampled on the system clock through a synchroniser chain. The output is presented as a data bit plus a drive enable, which the pad uses to build a tri-state line.

Top module: `serial_nvm_dev`

## Requirements
- R1: While select is high, rising serial-clock edges with the input low are ignored. The first rising edge with the input high is the start bit. Nothing is decoded while select is low.
- R2: Opcode 10 followed by address A5..A0 is a read. After the last address bit the output drives a 0 dummy bit, and each following rising edge presents the next data bit, D15 first.
- R3: A read held open continues with the next word at address+1, wrapping 63 to 0, with no further dummy bit.
- R4: Opcode 01, then the address, then 16 data bits, stores the word. The store takes effect when select falls after the last bit.
- R5: The enable latch is clear after reset. Opcode 00 with address bits A5..A4 = 11 sets it, and 00 with A5..A4 = 00 clears it. While it is clear, store and erase instructions change nothing and start no cycle. Reads still work.
- R6: Opcode 11 with an address sets that word to 0xFFFF. Opcode 00 with A5..A4 = 10 sets every word to 0xFFFF.
- R7: Opcode 00 with A5..A4 = 01, followed by 16 data bits, stores that data in every word.
- R8: After a cycle starts, raising select drives the output with 0 while busy and 1 once ready. Ready is also shown if select stayed low for the whole cycle. The drive enable is low after reset and goes low after select falls.
- R9: An instruction cut short by select falling before its last bit has no effect.
- R10: Start bits arriving while a cycle is busy are ignored, so the whole instruction is lost.
- R11: After the final bit of an instruction, further clocks and input bits are ignored until the next start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock used for sampling and cycle timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Device select, high = selected |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Drive enable for the serial output (low = high impedance) |

## Verification
If the bit counter or the decoder goes wrong, the very next read shows it: the dummy bit lands in the wrong position, or the word comes out shifted or belongs to a neighbouring address, within one instruction frame. If the enable latch or the launch logic is wrong, the fault shows up either as a busy status where none should appear, or as stored contents that changed, once the following cycle has finished. If the busy timer is wrong, polling reaches ready too early or too late, or the poll never ends.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_READ, ST_ARM, ST_DONE
  } nvm_state_e;

  typedef enum logic [1:0] {
    PG_ERASE, PG_WRITE, PG_ERAL, PG_WRAL
  } prog_kind_e;

  localparam logic [1:0] OP_EXT  = 2'b00;
  localparam logic [1:0] OP_STORE = 2'b01;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam logic [1:0] OP_CLR  = 2'b11;

  localparam logic [1:0] EXT_DIS  = 2'b00;
  localparam logic [1:0] EXT_FILL = 2'b01;
  localparam logic [1:0] EXT_WIPE = 2'b10;
  localparam logic [1:0] EXT_EN   = 2'b11;
endpackage

// File: rtl/nvm_pin_sync.sv
module nvm_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_in,
  input  logic sclk_in,
  input  logic sdi_in,
  output logic sel,
  output logic sdi,
  output logic sclk_rise,
  output logic sel_rise,
  output logic sel_fall
);
  logic [2:0] stg_q [STAGES];
  logic [2:0] stg_d [STAGES];
  logic       sclk_prev_q, sel_prev_q;

  always_comb begin
    stg_d[0] = {sel_in, sclk_in, sdi_in};
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      sclk_prev_q <= 1'b0;
      sel_prev_q  <= 1'b0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
      sclk_prev_q <= stg_q[STAGES-1][1];
      sel_prev_q  <= stg_q[STAGES-1][2];
    end
  end

  assign sel       = stg_q[STAGES-1][2];
  assign sdi       = stg_q[STAGES-1][0];
  assign sclk_rise = stg_q[STAGES-1][1] & ~sclk_prev_q;
  assign sel_rise  = sel & ~sel_prev_q;
  assign sel_fall  = ~sel & sel_prev_q;
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int CYCLES = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)             cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R8
  busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_all,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (wr_all || (wr_addr == AW'(i)))) mem[i] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
  import nvm_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          sdi,
  input  logic          sclk_rise,
  input  logic          sel_rise,
  input  logic          sel_fall,
  input  logic          busy,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic          wr_all,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          sdo_en
);
  localparam int CNTW = $clog2(DW);

  nvm_state_e    state_q, state_d;
  prog_kind_e    kind_q, kind_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [1:0]    op_q, op_d;
  logic [AW-1:0] adr_q, adr_d;
  logic [DW-1:0] dat_q, dat_d;
  logic [DW-1:0] rd_sh_q, rd_sh_d;
  logic          wen_q, wen_d;
  logic          rd_bit_q, rd_bit_d;
  logic          rd_oe_q, rd_oe_d;
  logic          stat_pend_q, stat_pend_d;
  logic          stat_show_q, stat_show_d;
  logic [AW-1:0] nadr;
  logic          launch;

  assign nadr   = {adr_q[AW-2:0], sdi};
  assign launch = sel_fall && (state_q == ST_ARM);

  always_comb begin
    state_d     = state_q;
    kind_d      = kind_q;
    cnt_d       = cnt_q;
    op_d        = op_q;
    adr_d       = adr_q;
    dat_d       = dat_q;
    rd_sh_d     = rd_sh_q;
    wen_d       = wen_q;
    rd_bit_d    = rd_bit_q;
    rd_oe_d     = rd_oe_q;
    stat_pend_d = stat_pend_q;
    stat_show_d = stat_show_q;

    if (launch) stat_pend_d = 1'b1;

    if (!sel) begin
      state_d     = ST_IDLE;
      rd_oe_d     = 1'b0;
      stat_show_d = 1'b0;
    end else begin
      if (sel_rise && stat_pend_q) stat_show_d = 1'b1;
      if (sclk_rise) begin
        unique case (state_q)
          ST_IDLE: begin
            if (sdi && !busy) begin
              state_d     = ST_OPC;
              cnt_d       = '0;
              stat_pend_d = 1'b0;
              stat_show_d = 1'b0;
            end
          end
          ST_OPC: begin
            op_d = {op_q[0], sdi};
            if (cnt_q == CNTW'(1)) begin
              state_d = ST_ADR;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          ST_ADR: begin
            adr_d = nadr;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNTW'(AW-1)) begin
              cnt_d = '0;
              unique case (op_q)
                OP_READ: begin
                  state_d  = ST_READ;
                  rd_sh_d  = rd_data;
                  rd_bit_d = 1'b0;
                  rd_oe_d  = 1'b1;
                end
                OP_STORE: begin
                  state_d = ST_DAT;
                  kind_d  = PG_WRITE;
                end
                OP_CLR: begin
                  kind_d  = PG_ERASE;
                  state_d = wen_q ? ST_ARM : ST_DONE;
                end
                default: begin
                  unique case (nadr[AW-1:AW-2])
                    EXT_EN: begin
                      wen_d   = 1'b1;
                      state_d = ST_DONE;
                    end
                    EXT_DIS: begin
                      wen_d   = 1'b0;
                      state_d = ST_DONE;
                    end
                    EXT_WIPE: begin
                      kind_d  = PG_ERAL;
                      state_d = wen_q ? ST_ARM : ST_DONE;
                    end
                    default: begin
                      kind_d  = PG_WRAL;
                      state_d = ST_DAT;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DAT: begin
            dat_d = {dat_q[DW-2:0], sdi};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNTW'(DW-1)) begin
              cnt_d   = '0;
              state_d = wen_q ? ST_ARM : ST_DONE;
            end
          end
          ST_READ: begin
            rd_bit_d = rd_sh_q[DW-1];
            if (cnt_q == CNTW'(DW-1)) begin
              rd_sh_d = rd_data;
              adr_d   = adr_q + 1'b1;
              cnt_d   = '0;
            end else begin
              rd_sh_d = {rd_sh_q[DW-2:0], 1'b0};
              cnt_d   = cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      kind_q      <= PG_ERASE;
      cnt_q       <= '0;
      op_q        <= '0;
      adr_q       <= '0;
      dat_q       <= '0;
      rd_sh_q     <= '0;
      wen_q       <= 1'b0;
      rd_bit_q    <= 1'b0;
      rd_oe_q     <= 1'b0;
      stat_pend_q <= 1'b0;
      stat_show_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      kind_q      <= kind_d;
      cnt_q       <= cnt_d;
      op_q        <= op_d;
      adr_q       <= adr_d;
      dat_q       <= dat_d;
      rd_sh_q     <= rd_sh_d;
      wen_q       <= wen_d;
      rd_bit_q    <= rd_bit_d;
      rd_oe_q     <= rd_oe_d;
      stat_pend_q <= stat_pend_d;
      stat_show_q <= stat_show_d;
    end
  end

  assign rd_addr = (state_q == ST_ADR) ? nadr : adr_q + 1'b1;
  assign wr_en   = launch;
  assign wr_all  = (kind_q == PG_ERAL) || (kind_q == PG_WRAL);
  assign wr_addr = adr_q;
  assign wr_data = ((kind_q == PG_ERASE) || (kind_q == PG_ERAL)) ? '1 : dat_q;
  assign sdo     = stat_show_q ? ~busy : rd_bit_q;
  assign sdo_en  = stat_show_q | rd_oe_q;

  // R5
  launch_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wen_q);
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && busy) |=> (state_q == ST_IDLE));
  // R8
  sdo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !sdo_en);
  // R2
  read_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe_q) |-> !rd_bit_q);
endmodule

// File: rtl/serial_nvm_dev.sv
module serial_nvm_dev #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic [1:0]    rst_sync_q;
  logic          srst_n;
  logic          sel, sdi, sclk_rise, sel_rise, sel_fall;
  logic          busy, wr_en, wr_all;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  nvm_pin_sync #(.STAGES(SYNC_STAGES)) u_pins (
    .clk       (clk),
    .rst_n     (srst_n),
    .sel_in    (sel_i),
    .sclk_in   (sclk_i),
    .sdi_in    (sdi_i),
    .sel       (sel),
    .sdi       (sdi),
    .sclk_rise (sclk_rise),
    .sel_rise  (sel_rise),
    .sel_fall  (sel_fall)
  );

  nvm_cmd_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .sel       (sel),
    .sdi       (sdi),
    .sclk_rise (sclk_rise),
    .sel_rise  (sel_rise),
    .sel_fall  (sel_fall),
    .busy      (busy),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_all    (wr_all),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sdo       (sdo_o),
    .sdo_en    (sdo_oe_o)
  );

  nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (srst_n),
    .start (wr_en),
    .busy  (busy)
  );

  nvm_array #(.AW(AW), .DW(DW)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_all  (wr_all),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R10
  wr_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en |-> !busy);
endmodule

// File: tb/tb_serial_nvm_dev.sv
module tb_serial_nvm_dev;
  localparam int PROG = 1500;

  logic clk = 1'b0;
  logic rst_n, sel, sclk, sdi;
  logic sdo, sdo_en;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  serial_nvm_dev dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, output logic q);
    sdi = b;  tick(3);
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(4);
    q = sdo;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic q;
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i], q);
  endtask

  task automatic cmd_begin();
    sel = 1'b1; tick(4);
    send(1, 1);
  endtask

  task automatic cmd_end();
    sel = 1'b0; sdi = 1'b0; tick(6);
  endtask

  task automatic ext_cmd(input logic [1:0] sub);
    cmd_begin(); send(2'b00, 2); send({sub, 4'b0000}, 6); cmd_end();
  endtask

  task automatic store_cmd(input logic [5:0] a, input logic [15:0] d);
    cmd_begin(); send(2'b01, 2); send(a, 6); send(d, 16); cmd_end();
  endtask

  task automatic wait_ready(input bit expect_busy, input string req);
    int k;
    sel = 1'b1; tick(8);
    check(sdo_en === 1'b1, req, sdo_en, 1);
    if (expect_busy) check(sdo === 1'b0, req, sdo, 0);
    k = 0;
    while (sdo !== 1'b1 && k < PROG + 200) begin tick(1); k++; end
    check(sdo === 1'b1, req, sdo, 1);
    cmd_end();
  endtask

  task automatic no_cycle(input string req);
    sel = 1'b1; tick(8);
    check(sdo_en === 1'b0, req, sdo_en, 0);
    cmd_end();
  endtask

  task automatic read_expect(input logic [5:0] a, input int n, input logic [15:0] e0,
                             input logic [15:0] e1, input logic [15:0] e2,
                             input string req);
    logic q;
    logic [15:0] w;
    logic [15:0] exp;
    cmd_begin(); send(2'b10, 2);
    for (int i = 5; i >= 0; i--) shift_bit(a[i], q);
    check(sdo_en === 1'b1 && q === 1'b0, "R2 dummy", {sdo_en, q}, 2'b10);
    for (int j = 0; j < n; j++) begin
      for (int i = 0; i < 16; i++) begin shift_bit(1'b0, q); w = {w[14:0], q}; end
      exp = (j == 0) ? e0 : (j == 1) ? e1 : e2;
      check(w === exp, req, w, exp);
    end
    cmd_end();
  endtask

  task automatic t_reset();
    check(sdo_en === 1'b0, "R8 reset", sdo_en, 0);
    // R5: fill while latch clear starts nothing
    cmd_begin(); send(2'b00, 2); send(6'b010000, 6); send(16'h1234, 16); cmd_end();
    no_cycle("R5 disabled fill");
  endtask

  task automatic t_fill();
    ext_cmd(2'b11);
    cmd_begin(); send(2'b00, 2); send(6'b010000, 6); send(16'h1234, 16); cmd_end();
    wait_ready(1, "R8 fill busy");
    read_expect(6'd0, 3, 16'h1234, 16'h1234, 16'h1234, "R7 fill");
    read_expect(6'd40, 1, 16'h1234, 0, 0, "R7 fill mid");
  endtask

  task automatic t_store();
    // R1: clocks with sel low and with sdi low before the start bit
    sel = 1'b0; send(3'b111, 3);
    sel = 1'b1; tick(4); send(3'b000, 3);
    send(1, 1); send(2'b01, 2); send(6'd5, 6); send(16'hBEEF, 16);
    send(4'b1111, 4); // R11 trailing clocks
    cmd_end();
    wait_ready(1, "R4 store busy");
    read_expect(6'd4, 3, 16'h1234, 16'hBEEF, 16'h1234, "R1 R4 R11 store");
  endtask

  task automatic t_wrap();
    store_cmd(6'd62, 16'hA5A5); wait_ready(1, "R4");
    store_cmd(6'd63, 16'h5A5A); wait_ready(1, "R4");
    store_cmd(6'd0,  16'h0F0F); wait_ready(1, "R4");
    read_expect(6'd62, 3, 16'hA5A5, 16'h5A5A, 16'h0F0F, "R3 wrap");
  endtask

  task automatic t_disabled();
    ext_cmd(2'b00);
    store_cmd(6'd5, 16'h0000); no_cycle("R5 store off");
    cmd_begin(); send(2'b11, 2); send(6'd5, 6); cmd_end(); no_cycle("R5 erase off");
    ext_cmd(2'b10); no_cycle("R5 wipe off");
    read_expect(6'd4, 3, 16'h1234, 16'hBEEF, 16'h1234, "R5 contents kept");
  endtask

  task automatic t_erase();
    ext_cmd(2'b11);
    cmd_begin(); send(2'b11, 2); send(6'd5, 6); cmd_end();
    tick(PROG + 50);
    sel = 1'b1; tick(8);
    check(sdo_en === 1'b1 && sdo === 1'b1, "R8 late ready", {sdo_en, sdo}, 2'b11);
    cmd_end();
    read_expect(6'd4, 3, 16'h1234, 16'hFFFF, 16'h1234, "R6 erase");
  endtask

  task automatic t_partial();
    cmd_begin(); send(2'b01, 2); send(6'd6, 6); send(10'h155, 10); cmd_end();
    no_cycle("R9 cut short");
    read_expect(6'd6, 1, 16'h1234, 0, 0, "R9 word kept");
  endtask

  task automatic t_busy();
    store_cmd(6'd7, 16'h7777);
    sel = 1'b1; tick(8);
    check(sdo_en === 1'b1 && sdo === 1'b0, "R8 busy shown", {sdo_en, sdo}, 2'b10);
    send(1, 1); send(2'b01, 2); send(6'd8, 6); send(16'h8888, 16);
    cmd_end();
    wait_ready(0, "R8 ready");
    read_expect(6'd7, 3, 16'h7777, 16'h1234, 16'h1234, "R10 busy ignore");
  endtask

  task automatic t_wipe();
    ext_cmd(2'b10);
    wait_ready(1, "R8 wipe busy");
    read_expect(6'd63, 3, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R6 wipe");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; sclk = 1'b0; sdi = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);
    t_reset();
    t_fill();
    t_store();
    t_wrap();
    t_disabled();
    t_erase();
    t_partial();
    t_busy();
    t_wipe();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule